// File: doc/BRIEF.md
# Load/Store Queue Occupancy and Store Writeback Controller

This block keeps the bookkeeping for one thread's memory instructions: a circular queue of loads and a circular queue of stores, each tagged with a sequence number that grows in program order. It tracks head and tail pointers and occupancy for both queues. It frees older entries when the pipeline commits up to a sequence number, and it cuts off younger entries when the pipeline squashes. It also reports full and free-slot status to the dispatch stage.

Stores take a longer path than loads. A store slot gets its data and size written by index while it waits. A commit marks it as allowed to write back. A third pointer, the writeback pointer, then walks from the store head toward the tail and sends one committed store per cycle to the data-cache port. The slot is released only on the cycle after its writeback. Loads that execute share the cache port with the writeback path. The block decides whether a load may go ahead, must be rescheduled because it is uncacheable and not yet safe, or is blocked by the cache. For blocked loads it records the oldest one.

The cache has CACHE_PORTS access ports per cycle, and a load always has priority over a store writeback for them. Sequence numbers are compared as plain unsigned values. Both depths must be powers of two.

Top module: `lsq_track_top`

## Requirements
- R1: Each queue of DEPTH slots holds at most DEPTH-1 entries, because one slot stays empty. Its full flag is high when the count reaches DEPTH-1. An insert into a full queue is ignored and leaves the count and tail index unchanged.
- R2: `lsq_full` is the OR of the two full flags. `free_slots` is the smaller of (LQ_DEPTH-1-lq_count) and (SQ_DEPTH-1-sq_count).
- R3: A commit with sequence number N releases, at the next clock edge, every load whose sequence number is below N, and advances the load head by that many slots.
- R4: The same commit marks every store below N as committed and allowed to write back, without releasing it. A store leaves `sq_count` on the clock edge after the edge on which it was written back. `st_wb_pending` counts the stores that are committed but not yet written back.
- R5: Inserting a store clears its data, size and all three flags, even when the slot held an earlier store that was written back. A data write by index stores data and size, and those values appear on `dc_st_data`/`dc_st_size` when that slot is written back.
- R6: `dc_st_vld` is high only when the slot at the writeback pointer is committed and not yet written back, `dc_blocked` is low, and a port is free. Stores leave in queue order, one per cycle.
- R7: A load that goes to the cache (`ld_go`) uses a port first. With CACHE_PORTS=1, no store writeback is issued in the same cycle, and the held store goes out on the next cycle without a load.
- R8: An uncacheable load gets `ld_go` only if its index equals the load head and it has reached commit (`ld_exe_atc`). Otherwise `ld_resched` is raised and `ld_go` stays low.
- R9: A cacheable, non-rescheduled load that meets `dc_blocked` sets `ld_blk` and stores its sequence number in `ld_blk_seq`, unless an older blocked load is already recorded. A recording in the same cycle as `ld_blk_clr` wins over the clear. `ld_blk_clr` alone drops the flag.
- R10: A squash with sequence number S removes every load and store above S by moving the tails back and reducing the counts at the next edge. Inserts in the squash cycle are ignored. A commit in the same cycle is applied too, against the state before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_ins_vld | input | 1 | Insert a load at the load tail |
| ld_ins_seq | input | SEQ_W | Sequence number of inserted load |
| st_ins_vld | input | 1 | Insert a store at the store tail |
| st_ins_seq | input | SEQ_W | Sequence number of inserted store |
| st_wr_vld | input | 1 | Write data and size into a store slot |
| st_wr_idx | input | log2(SQ_DEPTH) | Store slot to write |
| st_wr_size | input | SIZE_W | Store size in bytes |
| st_wr_data | input | DATA_W | Store data |
| cmt_vld | input | 1 | Commit everything below cmt_seq |
| cmt_seq | input | SEQ_W | Commit boundary |
| sqh_vld | input | 1 | Squash everything above sqh_seq |
| sqh_seq | input | SEQ_W | Squash boundary |
| ld_exe_vld | input | 1 | A load asks to access the cache |
| ld_exe_idx | input | log2(LQ_DEPTH) | Load queue slot of that load |
| ld_exe_unc | input | 1 | Load is uncacheable |
| ld_exe_atc | input | 1 | Load has reached commit |
| ld_go | output | 1 | Load proceeds to the cache this cycle |
| ld_resched | output | 1 | Load rejected, must be rescheduled |
| ld_blk | output | 1 | A load was blocked by the cache |
| ld_blk_seq | output | SEQ_W | Sequence number of the oldest blocked load |
| ld_blk_clr | input | 1 | Clear the blocked-load record |
| dc_blocked | input | 1 | Cache cannot accept accesses this cycle |
| dc_st_vld | output | 1 | Store writeback issued this cycle |
| dc_st_idx | output | log2(SQ_DEPTH) | Store slot being written back |
| dc_st_data | output | DATA_W | Data of that store |
| dc_st_size | output | SIZE_W | Size of that store |
| lq_count | output | log2(LQ_DEPTH)+1 | Loads held |
| sq_count | output | log2(SQ_DEPTH)+1 | Stores held |
| lq_full | output | 1 | Load queue full |
| sq_full | output | 1 | Store queue full |
| lsq_full | output | 1 | Either queue full |
| free_slots | output | log2(max depth)+1 | Smaller of the two free counts |
| lq_head_idx | output | log2(LQ_DEPTH) | Oldest load slot |
| lq_tail_idx | output | log2(LQ_DEPTH) | Slot the next load takes |
| sq_tail_idx | output | log2(SQ_DEPTH) | Slot the next store takes |
| st_wb_pending | output | log2(SQ_DEPTH)+1 | Committed stores not yet written back |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a load executing and a committed store waiting at the writeback pointer. The bench holds the store ready and drives a cacheable load in that cycle. It expects `ld_go` high and `dc_st_vld` low, then expects the same store on the port in the next load-free cycle. The second pair is commit and squash. The bench applies both in one cycle, plus a squash alongside inserts. It judges the outcome from the counts and tail indices it computes itself, and from the writeback of the newly committed store that must follow.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

  // next position on a ring of d slots, n steps ahead
  function automatic int unsigned ring_next(input int unsigned p, input int unsigned n,
                                            input int unsigned d);
    return (p + n) % d;
  endfunction

  // steps from 'from' to 'to' walking forward on a ring of d slots
  function automatic int unsigned ring_gap(input int unsigned from, input int unsigned to,
                                           input int unsigned d);
    return (to + d - from) % d;
  endfunction

  // usable slots left when one slot is kept empty
  function automatic int unsigned room_left(input int unsigned depth, input int unsigned used);
    return (depth - 1) - used;
  endfunction

  function automatic int unsigned min_u(input int unsigned a, input int unsigned b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/lsq_load_ring.sv
module lsq_load_ring
  import lsq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int SEQ_W = 16,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_vld,
  input  logic [SEQ_W-1:0] ins_seq,
  input  logic             cmt_vld,
  input  logic [SEQ_W-1:0] cmt_seq,
  input  logic             sqh_vld,
  input  logic [SEQ_W-1:0] sqh_seq,
  input  logic [PW-1:0]    rd_idx,
  output logic [SEQ_W-1:0] rd_seq,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic [PW-1:0]    head,
  output logic [PW-1:0]    tail
);

  logic [SEQ_W-1:0] seq_q [DEPTH];
  logic [PW-1:0]    head_q, tail_q;
  logic [CW-1:0]    cnt_q;
  int unsigned      free_n, kill_n;
  logic             ins_ok;

  always_comb begin
    free_n = 0;
    kill_n = 0;
    for (int i = 0; i < DEPTH; i++) begin
      if (ring_gap(32'(head_q), i, DEPTH) < 32'(cnt_q)) begin
        if (cmt_vld && (seq_q[i] < cmt_seq)) free_n = free_n + 1;
        else if (sqh_vld && (seq_q[i] > sqh_seq)) kill_n = kill_n + 1;
      end
    end
  end

  assign full   = (cnt_q >= CW'(DEPTH - 1));
  assign ins_ok = ins_vld && !full && !sqh_vld;
  assign rd_seq = seq_q[rd_idx];
  assign count  = cnt_q;
  assign head   = head_q;
  assign tail   = tail_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= PW'(ring_next(32'(head_q), free_n, DEPTH));
      tail_q <= PW'(ring_next(32'(tail_q), DEPTH - kill_n + (ins_ok ? 1 : 0), DEPTH));
      cnt_q  <= cnt_q - CW'(free_n) - CW'(kill_n) + CW'(ins_ok);
      if (ins_ok) seq_q[tail_q] <= ins_seq;
    end
  end

  // R1: never more than DEPTH-1 loads held
  p_lq_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH - 1));

  // R1: a full queue with no commit or squash keeps its count
  p_lq_full_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !cmt_vld && !sqh_vld) |=> (cnt_q == $past(cnt_q)));

  // R10: a squash cycle never grows the queue
  p_lq_squash_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sqh_vld |=> (cnt_q <= $past(cnt_q)));

endmodule

// File: rtl/lsq_store_ring.sv
module lsq_store_ring
  import lsq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int SEQ_W  = 16,
  parameter int DATA_W = 64,
  parameter int SIZE_W = 4,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_vld,
  input  logic [SEQ_W-1:0]  ins_seq,
  input  logic              wr_vld,
  input  logic [PW-1:0]     wr_idx,
  input  logic [SIZE_W-1:0] wr_size,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cmt_vld,
  input  logic [SEQ_W-1:0]  cmt_seq,
  input  logic              sqh_vld,
  input  logic [SEQ_W-1:0]  sqh_seq,
  input  logic              wb_fire,
  output logic              wb_cand,
  output logic [PW-1:0]     wb_idx,
  output logic [DATA_W-1:0] wb_data,
  output logic [SIZE_W-1:0] wb_size,
  output logic [CW-1:0]     count,
  output logic [CW-1:0]     pending,
  output logic              full,
  output logic [PW-1:0]     tail
);

  logic [SEQ_W-1:0]  seq_q  [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [SIZE_W-1:0] size_q [DEPTH];
  logic [DEPTH-1:0]  canwb_q, cmtd_q, done_q;
  logic [PW-1:0]     head_q, wbp_q, tail_q;
  logic [CW-1:0]     cnt_q;
  int unsigned       rel_n, kill_n, pend_n;
  logic              ins_ok, rel_any;
  logic [DEPTH-1:0]  live;

  always_comb begin
    kill_n = 0;
    pend_n = 0;
    for (int i = 0; i < DEPTH; i++) begin
      live[i] = ring_gap(32'(head_q), i, DEPTH) < 32'(cnt_q);
      if (live[i] && sqh_vld && (seq_q[i] > sqh_seq)) kill_n = kill_n + 1;
      if (live[i] && cmtd_q[i] && !done_q[i]) pend_n = pend_n + 1;
    end
    rel_n = ring_gap(32'(head_q), 32'(wbp_q), DEPTH);
  end

  assign rel_any = (rel_n != 0);
  assign full    = (cnt_q >= CW'(DEPTH - 1));
  assign ins_ok  = ins_vld && !full && !sqh_vld;
  assign wb_cand = live[wbp_q] && canwb_q[wbp_q] && !done_q[wbp_q];
  assign wb_idx  = wbp_q;
  assign wb_data = data_q[wbp_q];
  assign wb_size = size_q[wbp_q];
  assign count   = cnt_q;
  assign pending = CW'(pend_n);
  assign tail    = tail_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      wbp_q   <= '0;
      tail_q  <= '0;
      cnt_q   <= '0;
      canwb_q <= '0;
      cmtd_q  <= '0;
      done_q  <= '0;
    end else begin
      // slots already written back leave the queue
      head_q <= wbp_q;
      if (wb_fire) begin
        wbp_q          <= PW'(ring_next(32'(wbp_q), 1, DEPTH));
        done_q[wbp_q]  <= 1'b1;
      end
      for (int i = 0; i < DEPTH; i++) begin
        if (live[i] && cmt_vld && (seq_q[i] < cmt_seq)) begin
          canwb_q[i] <= 1'b1;
          cmtd_q[i]  <= 1'b1;
        end
      end
      tail_q <= PW'(ring_next(32'(tail_q), DEPTH - kill_n + (ins_ok ? 1 : 0), DEPTH));
      cnt_q  <= cnt_q - CW'(rel_n) - CW'(kill_n) + CW'(ins_ok);
      if (ins_ok) begin
        seq_q[tail_q]   <= ins_seq;
        data_q[tail_q]  <= '0;
        size_q[tail_q]  <= '0;
        canwb_q[tail_q] <= 1'b0;
        cmtd_q[tail_q]  <= 1'b0;
        done_q[tail_q]  <= 1'b0;
      end
      if (wr_vld) begin
        data_q[wr_idx] <= wr_data;
        size_q[wr_idx] <= wr_size;
      end
    end
  end

  // R1: never more than DEPTH-1 stores held
  p_sq_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH - 1));

  // R4: with nothing written back and no squash, commit cannot shrink the queue
  p_sq_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rel_any && !sqh_vld) |=> (cnt_q >= $past(cnt_q)));

  // R6: the writeback engine only fires on a committed, unfinished slot
  p_wb_cand_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_fire |-> wb_cand);

  // R4: the pending count never exceeds the occupancy
  p_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pending <= cnt_q);

endmodule

// File: rtl/lsq_port_arb.sv
module lsq_port_arb #(
  parameter int SEQ_W       = 16,
  parameter int PW          = 4,
  parameter int CACHE_PORTS = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_vld,
  input  logic [PW-1:0]    ld_idx,
  input  logic             ld_unc,
  input  logic             ld_atc,
  input  logic [SEQ_W-1:0] ld_seq,
  input  logic [PW-1:0]    lq_head,
  input  logic             dc_blocked,
  input  logic             st_cand,
  input  logic             blk_clr,
  output logic             ld_go,
  output logic             ld_resched,
  output logic             st_fire,
  output logic             blk_flag,
  output logic [SEQ_W-1:0] blk_seq,
  output logic [1:0]       ports_used
);

  logic             unc_unsafe, ld_try, blk_hit, blk_q, take;
  logic [SEQ_W-1:0] bseq_q;

  assign unc_unsafe = ld_unc && !((ld_idx == lq_head) && ld_atc);
  assign ld_resched = ld_vld && unc_unsafe;
  assign ld_try     = ld_vld && !unc_unsafe;
  assign ld_go      = ld_try && !dc_blocked;
  assign blk_hit    = ld_try && dc_blocked;
  assign st_fire    = st_cand && !dc_blocked && ((ld_go ? 1 : 0) < CACHE_PORTS);
  assign ports_used = 2'(ld_go) + 2'(st_fire);
  assign take       = blk_hit && (!blk_q || blk_clr || (ld_seq < bseq_q));
  assign blk_flag   = blk_q;
  assign blk_seq    = bseq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_q  <= 1'b0;
      bseq_q <= '0;
    end else if (take) begin
      blk_q  <= 1'b1;
      bseq_q <= ld_seq;
    end else if (blk_clr) begin
      blk_q  <= 1'b0;
    end
  end

  // R7: accesses per cycle never exceed the port count
  p_ports_r7: assert property (@(posedge clk) disable iff (!rst_n)
    32'(ports_used) <= CACHE_PORTS);

  // R8: an uncacheable load proceeds only from the head once at commit
  p_unc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_go && ld_unc) |-> ((ld_idx == lq_head) && ld_atc));

  // R9: a blocked record survives until cleared
  p_blk_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_q && !blk_clr) |=> blk_q);

  // R9: without a clear the recorded sequence number can only get older
  p_blk_older_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_q && !blk_clr) |=> (bseq_q <= $past(bseq_q)));

endmodule

// File: rtl/lsq_track_top.sv
module lsq_track_top
  import lsq_pkg::*;
#(
  parameter int LQ_DEPTH    = 16,
  parameter int SQ_DEPTH    = 16,
  parameter int SEQ_W       = 16,
  parameter int DATA_W      = 64,
  parameter int SIZE_W      = 4,
  parameter int CACHE_PORTS = 1,
  localparam int LPW = $clog2(LQ_DEPTH),
  localparam int SPW = $clog2(SQ_DEPTH),
  localparam int LCW = LPW + 1,
  localparam int SCW = SPW + 1,
  localparam int FW  = ((LQ_DEPTH > SQ_DEPTH) ? LPW : SPW) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_ins_vld,
  input  logic [SEQ_W-1:0]  ld_ins_seq,
  input  logic              st_ins_vld,
  input  logic [SEQ_W-1:0]  st_ins_seq,
  input  logic              st_wr_vld,
  input  logic [SPW-1:0]    st_wr_idx,
  input  logic [SIZE_W-1:0] st_wr_size,
  input  logic [DATA_W-1:0] st_wr_data,
  input  logic              cmt_vld,
  input  logic [SEQ_W-1:0]  cmt_seq,
  input  logic              sqh_vld,
  input  logic [SEQ_W-1:0]  sqh_seq,
  input  logic              ld_exe_vld,
  input  logic [LPW-1:0]    ld_exe_idx,
  input  logic              ld_exe_unc,
  input  logic              ld_exe_atc,
  output logic              ld_go,
  output logic              ld_resched,
  output logic              ld_blk,
  output logic [SEQ_W-1:0]  ld_blk_seq,
  input  logic              ld_blk_clr,
  input  logic              dc_blocked,
  output logic              dc_st_vld,
  output logic [SPW-1:0]    dc_st_idx,
  output logic [DATA_W-1:0] dc_st_data,
  output logic [SIZE_W-1:0] dc_st_size,
  output logic [LCW-1:0]    lq_count,
  output logic [SCW-1:0]    sq_count,
  output logic              lq_full,
  output logic              sq_full,
  output logic              lsq_full,
  output logic [FW-1:0]     free_slots,
  output logic [LPW-1:0]    lq_head_idx,
  output logic [LPW-1:0]    lq_tail_idx,
  output logic [SPW-1:0]    sq_tail_idx,
  output logic [SCW-1:0]    st_wb_pending
);

  logic [SEQ_W-1:0] exe_seq;
  logic             st_cand, st_fire;
  logic [1:0]       ports_used;

  lsq_load_ring #(.DEPTH(LQ_DEPTH), .SEQ_W(SEQ_W)) u_lq (
    .clk     (clk),
    .rst_n   (rst_n),
    .ins_vld (ld_ins_vld),
    .ins_seq (ld_ins_seq),
    .cmt_vld (cmt_vld),
    .cmt_seq (cmt_seq),
    .sqh_vld (sqh_vld),
    .sqh_seq (sqh_seq),
    .rd_idx  (ld_exe_idx),
    .rd_seq  (exe_seq),
    .count   (lq_count),
    .full    (lq_full),
    .head    (lq_head_idx),
    .tail    (lq_tail_idx)
  );

  lsq_store_ring #(.DEPTH(SQ_DEPTH), .SEQ_W(SEQ_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_sq (
    .clk     (clk),
    .rst_n   (rst_n),
    .ins_vld (st_ins_vld),
    .ins_seq (st_ins_seq),
    .wr_vld  (st_wr_vld),
    .wr_idx  (st_wr_idx),
    .wr_size (st_wr_size),
    .wr_data (st_wr_data),
    .cmt_vld (cmt_vld),
    .cmt_seq (cmt_seq),
    .sqh_vld (sqh_vld),
    .sqh_seq (sqh_seq),
    .wb_fire (st_fire),
    .wb_cand (st_cand),
    .wb_idx  (dc_st_idx),
    .wb_data (dc_st_data),
    .wb_size (dc_st_size),
    .count   (sq_count),
    .pending (st_wb_pending),
    .full    (sq_full),
    .tail    (sq_tail_idx)
  );

  lsq_port_arb #(.SEQ_W(SEQ_W), .PW(LPW), .CACHE_PORTS(CACHE_PORTS)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_vld     (ld_exe_vld),
    .ld_idx     (ld_exe_idx),
    .ld_unc     (ld_exe_unc),
    .ld_atc     (ld_exe_atc),
    .ld_seq     (exe_seq),
    .lq_head    (lq_head_idx),
    .dc_blocked (dc_blocked),
    .st_cand    (st_cand),
    .blk_clr    (ld_blk_clr),
    .ld_go      (ld_go),
    .ld_resched (ld_resched),
    .st_fire    (st_fire),
    .blk_flag   (ld_blk),
    .blk_seq    (ld_blk_seq),
    .ports_used (ports_used)
  );

  assign dc_st_vld  = st_fire;
  assign lsq_full   = lq_full || sq_full;
  assign free_slots = FW'(min_u(room_left(LQ_DEPTH, 32'(lq_count)),
                                room_left(SQ_DEPTH, 32'(sq_count))));

  // R6: nothing is sent to a blocked cache
  p_no_wb_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dc_st_vld |-> !dc_blocked);

  // R7: a going load and a store writeback share the single port only when allowed
  p_port_share_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_go && (CACHE_PORTS == 1)) |-> !dc_st_vld);

  // R2: unit full whenever no slot is free on either side
  p_full_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lsq_full |-> (free_slots == '0));

  // R8: a load is never both sent and rescheduled
  p_go_resched_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_go && ld_resched));

endmodule

// File: tb/lsq_track_top_tb_top.sv
module lsq_track_top_tb_top;

  localparam int D  = 4;
  localparam int SW = 8;
  localparam int DW = 16;
  localparam int ZW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic          ld_ins_vld, st_ins_vld, st_wr_vld, cmt_vld, sqh_vld;
  logic [SW-1:0] ld_ins_seq, st_ins_seq, cmt_seq, sqh_seq;
  logic [1:0]    st_wr_idx, ld_exe_idx;
  logic [ZW-1:0] st_wr_size;
  logic [DW-1:0] st_wr_data;
  logic          ld_exe_vld, ld_exe_unc, ld_exe_atc, ld_blk_clr, dc_blocked;
  logic          ld_go, ld_resched, ld_blk, dc_st_vld;
  logic [SW-1:0] ld_blk_seq;
  logic [1:0]    dc_st_idx, lq_head_idx, lq_tail_idx, sq_tail_idx;
  logic [DW-1:0] dc_st_data;
  logic [ZW-1:0] dc_st_size;
  logic [2:0]    lq_count, sq_count, free_slots, st_wb_pending;
  logic          lq_full, sq_full, lsq_full;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  lsq_track_top #(.LQ_DEPTH(D), .SQ_DEPTH(D), .SEQ_W(SW), .DATA_W(DW),
                  .SIZE_W(ZW), .CACHE_PORTS(1)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .ld_ins_vld(ld_ins_vld), .ld_ins_seq(ld_ins_seq),
    .st_ins_vld(st_ins_vld), .st_ins_seq(st_ins_seq),
    .st_wr_vld(st_wr_vld), .st_wr_idx(st_wr_idx), .st_wr_size(st_wr_size),
    .st_wr_data(st_wr_data),
    .cmt_vld(cmt_vld), .cmt_seq(cmt_seq), .sqh_vld(sqh_vld), .sqh_seq(sqh_seq),
    .ld_exe_vld(ld_exe_vld), .ld_exe_idx(ld_exe_idx), .ld_exe_unc(ld_exe_unc),
    .ld_exe_atc(ld_exe_atc), .ld_go(ld_go), .ld_resched(ld_resched),
    .ld_blk(ld_blk), .ld_blk_seq(ld_blk_seq), .ld_blk_clr(ld_blk_clr),
    .dc_blocked(dc_blocked), .dc_st_vld(dc_st_vld), .dc_st_idx(dc_st_idx),
    .dc_st_data(dc_st_data), .dc_st_size(dc_st_size),
    .lq_count(lq_count), .sq_count(sq_count), .lq_full(lq_full), .sq_full(sq_full),
    .lsq_full(lsq_full), .free_slots(free_slots), .lq_head_idx(lq_head_idx),
    .lq_tail_idx(lq_tail_idx), .sq_tail_idx(sq_tail_idx),
    .st_wb_pending(st_wb_pending)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    ld_ins_vld = 0; st_ins_vld = 0; st_wr_vld = 0; cmt_vld = 0; sqh_vld = 0;
    ld_exe_vld = 0; ld_exe_unc = 0; ld_exe_atc = 0; ld_blk_clr = 0;
  endtask

  function automatic int room(input int used);
    return (D - 1) - used;
  endfunction

  initial begin
    idle();
    ld_ins_seq = 0; st_ins_seq = 0; cmt_seq = 0; sqh_seq = 0;
    st_wr_idx = 0; st_wr_size = 0; st_wr_data = 0; ld_exe_idx = 0; dc_blocked = 0;
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk("R1 reset lq_count", lq_count, 0);
    chk("R1 reset sq_count", sq_count, 0);
    chk("R2 reset free_slots", free_slots, room(0));
    chk("R2 reset lsq_full", lsq_full, 0);
    chk("R6 reset dc_st_vld", dc_st_vld, 0);

    // fill the load queue, the fourth insert must be ignored
    for (int k = 0; k < 4; k++) begin
      ld_ins_vld = 1; ld_ins_seq = SW'(10 + k); tick();
    end
    idle();
    chk("R1 lq_count saturates", lq_count, D - 1);
    chk("R1 lq_full", lq_full, 1);
    chk("R1 lq_tail unchanged by ignored insert", lq_tail_idx, 3);
    chk("R2 lsq_full from load side", lsq_full, 1);

    st_ins_vld = 1; st_ins_seq = 20; tick();
    st_ins_seq = 21; tick();
    idle();
    chk("R1 sq_count", sq_count, 2);
    chk("R2 free_slots is the min", free_slots, 0);

    st_wr_vld = 1; st_wr_idx = 0; st_wr_size = 4; st_wr_data = 16'hA5A5; tick();
    st_wr_idx = 1; st_wr_size = 2; st_wr_data = 16'h1234; tick();
    idle();
    #1 chk("R6 uncommitted store held", dc_st_vld, 0);

    cmt_vld = 1; cmt_seq = 12; tick(); idle();
    chk("R3 loads below 12 released", lq_count, 1);
    chk("R3 lq head advanced", lq_head_idx, 2);
    chk("R4 stores untouched by commit 12", sq_count, 2);

    cmt_vld = 1; cmt_seq = 22; tick(); idle();
    chk("R3 last load released", lq_count, 0);
    chk("R4 committed stores kept", sq_count, 2);
    chk("R4 pending writebacks", st_wb_pending, 2);
    chk("R2 free_slots after commit", free_slots, 1);
    #1;
    chk("R6 oldest committed store issued", dc_st_vld, 1);
    chk("R6 issue index", dc_st_idx, 0);
    chk("R5 written data", dc_st_data, 16'hA5A5);
    chk("R5 written size", dc_st_size, 4);
    tick();
    chk("R4 store kept in writeback cycle", sq_count, 2);
    #1;
    chk("R6 next store in order", dc_st_idx, 1);
    dc_blocked = 1; ld_ins_vld = 1; ld_ins_seq = 25;
    #1 chk("R6 blocked cache holds writeback", dc_st_vld, 0);
    tick(); idle();
    chk("R4 store released after writeback", sq_count, 1);
    chk("R1 load 25 inserted", lq_count, 1);

    // load meets blocked cache: recorded
    ld_exe_vld = 1; ld_exe_idx = 3;
    #1 chk("R9 blocked load not sent", ld_go, 0);
    tick();
    chk("R9 blocked flag", ld_blk, 1);
    chk("R9 blocked seq", ld_blk_seq, 25);

    // port contention: load wins, store waits
    dc_blocked = 0;
    #1;
    chk("R7 load goes", ld_go, 1);
    chk("R7 store held behind load", dc_st_vld, 0);
    tick(); idle();
    #1;
    chk("R7 store goes without load", dc_st_vld, 1);
    chk("R5 second store data", dc_st_data, 16'h1234);
    chk("R5 second store size", dc_st_size, 2);
    tick(); tick();
    chk("R4 store queue drained", sq_count, 0);

    // blocked-load ordering
    ld_ins_vld = 1; ld_ins_seq = 27; tick(); idle();
    dc_blocked = 1; ld_exe_vld = 1; ld_exe_idx = 0; tick();
    chk("R9 younger load does not replace", ld_blk_seq, 25);
    ld_blk_clr = 1; tick();
    chk("R9 record wins over clear", ld_blk_seq, 27);
    chk("R9 flag after record with clear", ld_blk, 1);
    ld_blk_clr = 0; ld_exe_idx = 3; tick();
    chk("R9 older load replaces", ld_blk_seq, 25);
    idle(); ld_blk_clr = 1; tick(); idle();
    chk("R9 clear alone", ld_blk, 0);
    dc_blocked = 0;

    // uncacheable loads
    ld_exe_vld = 1; ld_exe_idx = 3; ld_exe_unc = 1; ld_exe_atc = 0;
    #1;
    chk("R8 head not at commit rescheduled", ld_resched, 1);
    chk("R8 head not at commit held", ld_go, 0);
    ld_exe_atc = 1;
    #1;
    chk("R8 head at commit goes", ld_go, 1);
    chk("R8 head at commit not rescheduled", ld_resched, 0);
    ld_exe_idx = 0;
    #1 chk("R8 non-head rescheduled", ld_resched, 1);
    tick(); idle();

    // squash with inserts in the same cycle
    st_ins_vld = 1; st_ins_seq = 40; ld_ins_vld = 1; ld_ins_seq = 42; tick(); idle();
    st_ins_vld = 1; st_ins_seq = 41; tick(); idle();
    chk("R1 lq full again", lq_full, 1);
    sqh_vld = 1; sqh_seq = 40; st_ins_vld = 1; st_ins_seq = 51; ld_ins_vld = 1; ld_ins_seq = 50;
    tick(); idle();
    chk("R10 loads above 40 removed", lq_count, 2);
    chk("R10 lq tail moved back", lq_tail_idx, 1);
    chk("R10 stores above 40 removed, insert ignored", sq_count, 1);
    chk("R10 sq tail moved back", sq_tail_idx, 3);

    // commit and squash together
    cmt_vld = 1; cmt_seq = 41; sqh_vld = 1; sqh_seq = 40; tick(); idle();
    chk("R10 commit with squash frees loads", lq_count, 0);
    chk("R10 store 40 survives squash", sq_count, 1);
    #1;
    chk("R10 committed store issued", dc_st_vld, 1);
    chk("R10 issue index", dc_st_idx, 2);
    tick(); tick();
    chk("R4 drained again", sq_count, 0);

    // refill stores into reused slots
    for (int k = 0; k < 4; k++) begin
      st_ins_vld = 1; st_ins_seq = SW'(60 + k); tick();
    end
    idle();
    chk("R1 sq_count saturates", sq_count, D - 1);
    chk("R1 sq_full", sq_full, 1);
    chk("R1 sq tail unchanged by ignored insert", sq_tail_idx, 2);
    chk("R2 free_slots min with empty lq", free_slots, 0);
    #1 chk("R5 reused slots start uncommitted", dc_st_vld, 0);
    chk("R5 nothing pending", st_wb_pending, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule